// File: doc/BRIEF.md
# Job Ring Queue Manager

This block keeps the bookkeeping for a pair of memory-resident rings shared between software and a processing engine. One ring holds submitted jobs and the other holds completion results. Software programs each ring's base and entry count. It hands jobs over by writing how many it has added, and it hands result slots back by writing how many it has consumed. The block tracks the pending jobs, the slots still free for submission, the filled result slots, and the two hardware-owned positions: the next job to fetch and the next result slot to fill.

The engine sees a fetch handshake that carries the ring position of the next job, and a post handshake that takes completed results while result slots remain. The memory transfers themselves are done elsewhere, using the base addresses and positions this block drives out. Several conditions are reported as typed errors: a count that would overflow the ring, and a reset request made while a reset is already under way. A ring reset first drains work already in flight, then clears all positions and counts, and waits for software to acknowledge before it resumes.

Top module: `jrq_manager`

## Requirements
- R1: After reset, every readable register reads 0, `fetch_req`, `post_ready` and `irq` are low. Register word addresses: 0 job base, 1 job size, 2 jobs-added (reads 0), 3 job room, 4 fetch position, 5 result base, 6 result size, 7 results-removed (reads 0), 8 results full, 9 post position, 10 interrupt status, 11 config, 12 command (reads 0).
- R2: Only the low 10 bits of a value written to either size register are kept.
- R3: The job room equals size minus pending jobs. A jobs-added write larger than the room leaves the ring unchanged and sets status bit 1 with type 9 in bits 11..8 and the written value's low 14 bits in bits 29..16. Otherwise the pending count grows by the written value.
- R4: A results-removed write larger than the full count leaves it unchanged and sets status bit 1 with type 8 and the written value as index. Otherwise the full count drops by the written value.
- R5: `fetch_req` is high while jobs are pending, the ring is running, no stop-on-error condition holds and fewer than 15 jobs are in flight. Each cycle with `fetch_req` and `fetch_ack` both high advances the fetch position by one, wrapping to 0 at the job size, and frees one slot of room.
- R6: `post_ready` is high while the full count is below the result size and the halt state is not complete. Each cycle with `post_valid` and `post_ready` both high advances the post position by one, wrapping to 0 at the result size, and adds one to the full count.
- R7: Writing 1 to command bit 0 while running sets the halt state (status bits 3..2) to 01 and drops `fetch_req`. Once no job is in flight, the state becomes 10 and both positions, the pending count, the full count and the in-flight count clear. Writing 1 to status bit 3 in state 10 returns the state to 00.
- R8: A reset request made while the halt state is not 00 sets status bit 1 with type 7 and index 0.
- R9: An accepted post sets status bit 0 when config bit 0 (mask) is 0. Writing 1 to status bit 0 clears it, and writing 1 to bit 1 clears the error bit, type and index. A set in the same cycle wins over a clear. `irq` equals (bit 0 or bit 1) and not mask.
- R10: With config bit 2 set, `fetch_req` stays low while status bit 1 is set.
- R11: Base registers read back what was written and drive `in_base` and `out_base`. The config register reads back all 32 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Register word address for reads |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt request |
| fetch_req | output | 1 | A job is available to fetch |
| fetch_ack | input | 1 | Engine takes the offered job |
| fetch_idx | output | 10 | Ring position of the offered job |
| in_base | output | 32 | Job ring base address |
| post_valid | input | 1 | Engine offers a completed result |
| post_ready | output | 1 | A result slot is free |
| post_idx | output | 10 | Ring position for the next result |
| out_base | output | 32 | Result ring base address |

## Verification
The hardest state to reach is the drain-then-complete halt sequence, together with the second reset request that must be flagged while a halt is pending. Both need jobs fetched but not yet posted when the command arrives. The stimulus first fetches more jobs than it posts, leaving one job in flight, and then issues the reset command twice. It then posts that last result and watches the clear land one cycle after the in-flight count reaches zero. Overflow on both counts and the stop-on-error gate are driven the same way: by writing counts just beyond the room or full values that the earlier traffic produced.

// File: rtl/jrq_pkg.sv
`timescale 1ns/100ps
// jrq_pkg: shared register addresses, halt encoding and error codes for
// the job ring queue manager. Assumes a 4-bit word-addressed register bus.
package jrq_pkg;
    localparam int unsigned AW  = 4;
    localparam int unsigned EIW = 14;

    localparam logic [AW-1:0] A_IN_BASE  = 4'd0;
    localparam logic [AW-1:0] A_IN_SIZE  = 4'd1;
    localparam logic [AW-1:0] A_IN_ADD   = 4'd2;
    localparam logic [AW-1:0] A_IN_ROOM  = 4'd3;
    localparam logic [AW-1:0] A_IN_IDX   = 4'd4;
    localparam logic [AW-1:0] A_OUT_BASE = 4'd5;
    localparam logic [AW-1:0] A_OUT_SIZE = 4'd6;
    localparam logic [AW-1:0] A_OUT_RM   = 4'd7;
    localparam logic [AW-1:0] A_OUT_FULL = 4'd8;
    localparam logic [AW-1:0] A_OUT_IDX  = 4'd9;
    localparam logic [AW-1:0] A_STAT     = 4'd10;
    localparam logic [AW-1:0] A_CFG      = 4'd11;
    localparam logic [AW-1:0] A_CMD      = 4'd12;

    localparam logic [3:0] ET_RESET   = 4'd7;
    localparam logic [3:0] ET_RM_OVF  = 4'd8;
    localparam logic [3:0] ET_ADD_OVF = 4'd9;

    typedef enum logic [1:0] {
        HALT_RUN   = 2'b00,
        HALT_DRAIN = 2'b01,
        HALT_DONE  = 2'b10
    } halt_e;
endpackage

// File: rtl/jrq_ring_track.sv
`timescale 1ns/100ps
// jrq_ring_track: keeps one ring's hardware position and occupancy count.
// SW_ADDS=1: software adds entries, hardware steps consume them (job ring).
// SW_ADDS=0: hardware steps fill entries, software removes them (result ring).
// Assumes the caller only steps when the ring allows it; clr has priority.
module jrq_ring_track #(
    parameter int unsigned SZW     = 10,
    parameter bit          SW_ADDS = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [SZW-1:0] size,
    input  logic           sw_we,
    input  logic [31:0]    sw_val,
    input  logic           hw_step,
    output logic [SZW-1:0] idx,
    output logic [SZW-1:0] cnt,
    output logic           ovf
);
    logic [SZW-1:0] limit;
    logic [SZW-1:0] take;
    logic [SZW-1:0] cnt_n;
    logic [SZW:0]   idx_inc;

    // Limit a software write may not exceed, and the next count.
    generate
        if (SW_ADDS) begin : g_adds
            always_comb begin
                limit = size - cnt;
                cnt_n = cnt + take - (hw_step ? SZW'(1) : SZW'(0));
            end
        end else begin : g_removes
            always_comb begin
                limit = cnt;
                cnt_n = cnt + (hw_step ? SZW'(1) : SZW'(0)) - take;
            end
        end
    endgenerate

    // Overflow detection and the accepted software amount.
    always_comb begin
        ovf     = sw_we && (sw_val > 32'(limit));
        take    = (sw_we && !ovf) ? sw_val[SZW-1:0] : '0;
        idx_inc = {1'b0, idx} + 1'b1;
    end

    // Position and count registers with wrap at the programmed size.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
            cnt <= '0;
        end else begin
            cnt <= cnt_n;
            if (hw_step) idx <= (idx_inc >= {1'b0, size}) ? '0 : idx_inc[SZW-1:0];
        end
    end

    // R3 / R4: a rejected software write leaves the occupancy untouched.
    p_ovf_holds_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && ovf && !hw_step && !clr) |=> $stable(cnt));
endmodule

// File: rtl/jrq_halt_ctl.sv
`timescale 1ns/100ps
// jrq_halt_ctl: ring reset sequencer. A request moves RUN to DRAIN; DRAIN
// waits for the engine to go idle, then pulses clr and enters DONE; DONE
// waits for software acknowledge. Assumes idle reflects in-flight jobs.
module jrq_halt_ctl
    import jrq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  logic  resume,
    input  logic  idle,
    output halt_e state,
    output logic  clr,
    output logic  req_err
);
    // Clear pulse and misplaced-request detection.
    always_comb begin
        clr     = (state == HALT_DRAIN) && idle;
        req_err = req && (state != HALT_RUN);
    end

    // Halt state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HALT_RUN;
        end else begin
            unique case (state)
                HALT_RUN:   if (req)    state <= HALT_DRAIN;
                HALT_DRAIN: if (idle)   state <= HALT_DONE;
                HALT_DONE:  if (resume) state <= HALT_RUN;
                default:                state <= HALT_RUN;
            endcase
        end
    end

    // R7: completion is never reported while work is still in flight.
    p_drain_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HALT_DRAIN && !idle) |=> (state != HALT_DONE));
endmodule

// File: rtl/jrq_manager.sv
`timescale 1ns/100ps
// jrq_manager: register front end of the job ring queue manager. Holds ring
// bases, sizes, config and interrupt status; instantiates one tracker per
// ring and the halt sequencer; counts jobs in flight inside the engine.
// Assumes single-cycle register writes and combinational reads.
module jrq_manager
    import jrq_pkg::*;
#(
    parameter int unsigned SZW = 10,
    parameter int unsigned IFW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [31:0]    wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [31:0]    rd_data,
    output logic           irq,
    output logic           fetch_req,
    input  logic           fetch_ack,
    output logic [SZW-1:0] fetch_idx,
    output logic [31:0]    in_base,
    input  logic           post_valid,
    output logic           post_ready,
    output logic [SZW-1:0] post_idx,
    output logic [31:0]    out_base
);
    localparam logic [IFW-1:0] IF_MAX = {IFW{1'b1}};

    logic [SZW-1:0] in_size, out_size, in_cnt, out_cnt;
    logic [31:0]    cfg;
    logic           int_q, err_q;
    logic [3:0]     err_type;
    logic [EIW-1:0] err_idx;
    logic [IFW-1:0] inflight;
    logic           we_add, we_rm, we_stat, we_cmd;
    logic           add_ovf, rm_ovf, halt_clr, req_err;
    logic           fetch_fire, post_fire, new_err;
    logic [3:0]     new_type;
    logic [EIW-1:0] new_idx;
    halt_e          halt_st;

    // Write decode for strobe-type registers.
    always_comb begin
        we_add  = wr_en && (wr_addr == A_IN_ADD);
        we_rm   = wr_en && (wr_addr == A_OUT_RM);
        we_stat = wr_en && (wr_addr == A_STAT);
        we_cmd  = wr_en && (wr_addr == A_CMD) && wr_data[0];
    end

    // Engine handshakes.
    always_comb begin
        fetch_req  = (in_cnt != '0) && (halt_st == HALT_RUN)
                     && !(cfg[2] && err_q) && (inflight != IF_MAX);
        post_ready = (out_cnt < out_size) && (halt_st != HALT_DONE);
        fetch_fire = fetch_req && fetch_ack;
        post_fire  = post_valid && post_ready;
        irq        = (int_q || err_q) && !cfg[0];
    end

    jrq_ring_track #(.SZW(SZW), .SW_ADDS(1'b1)) u_in_ring (
        .clk(clk), .rst_n(rst_n), .clr(halt_clr), .size(in_size),
        .sw_we(we_add), .sw_val(wr_data), .hw_step(fetch_fire),
        .idx(fetch_idx), .cnt(in_cnt), .ovf(add_ovf));

    jrq_ring_track #(.SZW(SZW), .SW_ADDS(1'b0)) u_out_ring (
        .clk(clk), .rst_n(rst_n), .clr(halt_clr), .size(out_size),
        .sw_we(we_rm), .sw_val(wr_data), .hw_step(post_fire),
        .idx(post_idx), .cnt(out_cnt), .ovf(rm_ovf));

    jrq_halt_ctl u_halt (
        .clk(clk), .rst_n(rst_n), .req(we_cmd),
        .resume(we_stat && wr_data[3]), .idle(inflight == '0),
        .state(halt_st), .clr(halt_clr), .req_err(req_err));

    // Error selection: add overflow first, then remove overflow, then reset.
    always_comb begin
        new_err  = add_ovf || rm_ovf || req_err;
        new_type = add_ovf ? ET_ADD_OVF : (rm_ovf ? ET_RM_OVF : ET_RESET);
        new_idx  = (add_ovf || rm_ovf) ? wr_data[EIW-1:0] : '0;
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_base <= '0; out_base <= '0; in_size <= '0; out_size <= '0; cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_IN_BASE:  in_base  <= wr_data;
                A_OUT_BASE: out_base <= wr_data;
                A_IN_SIZE:  in_size  <= wr_data[SZW-1:0];
                A_OUT_SIZE: out_size <= wr_data[SZW-1:0];
                A_CFG:      cfg      <= wr_data;
                default: ;
            endcase
        end
    end

    // Jobs handed to the engine but not yet returned.
    always_ff @(posedge clk) begin
        if (!rst_n || halt_clr) inflight <= '0;
        else if (fetch_fire && !(post_fire && inflight != '0)) inflight <= inflight + 1'b1;
        else if (!fetch_fire && post_fire && inflight != '0)  inflight <= inflight - 1'b1;
    end

    // Interrupt and error status; a set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= 1'b0; err_q <= 1'b0; err_type <= '0; err_idx <= '0;
        end else begin
            if (post_fire && !cfg[0])       int_q <= 1'b1;
            else if (we_stat && wr_data[0]) int_q <= 1'b0;
            if (new_err) begin
                err_q <= 1'b1; err_type <= new_type; err_idx <= new_idx;
            end else if (we_stat && wr_data[1]) begin
                err_q <= 1'b0; err_type <= '0; err_idx <= '0;
            end
        end
    end

    // Register read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_IN_BASE:  rd_data = in_base;
            A_IN_SIZE:  rd_data = 32'(in_size);
            A_IN_ROOM:  rd_data = 32'(in_size - in_cnt);
            A_IN_IDX:   rd_data = 32'(fetch_idx);
            A_OUT_BASE: rd_data = out_base;
            A_OUT_SIZE: rd_data = 32'(out_size);
            A_OUT_FULL: rd_data = 32'(out_cnt);
            A_OUT_IDX:  rd_data = 32'(post_idx);
            A_STAT:     rd_data = {2'b00, err_idx, 4'b0000, err_type, 4'b0000,
                                   halt_st, err_q, int_q};
            A_CFG:      rd_data = cfg;
            default:    rd_data = '0;
        endcase
    end

    // R9: an unmasked accepted post leaves the interrupt bit set.
    p_post_sets_int_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (post_fire && !cfg[0]) |=> int_q);
    // R3: a newly raised error always carries one of the defined types.
    p_err_type_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (err_type == ET_ADD_OVF || err_type == ET_RM_OVF
                          || err_type == ET_RESET));
    // R7: entering halt-complete finds both rings cleared.
    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_st == HALT_DONE && $past(halt_st) == HALT_DRAIN)
        |-> (fetch_idx == '0 && post_idx == '0 && in_cnt == '0 && out_cnt == '0));
endmodule

// File: tb/jrq_manager_tb.sv
`timescale 1ns/100ps
module jrq_manager_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        irq, fetch_req, post_ready, fetch_ack = 1'b0, post_valid = 1'b0;
    logic [9:0]  fetch_idx, post_idx;
    logic [31:0] in_base, out_base;

    logic        in_chk = 1'b0;
    logic [3:0]  c_addr = '0, e_addr = '0;
    int total = 0, bad = 0;
    bit done = 1'b0;

    assign rd_addr = in_chk ? c_addr : e_addr;

    always #10 clk = ~clk;

    jrq_manager u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .fetch_req(fetch_req),
        .fetch_ack(fetch_ack), .fetch_idx(fetch_idx), .in_base(in_base),
        .post_valid(post_valid), .post_ready(post_ready), .post_idx(post_idx),
        .out_base(out_base));

    // ---------------- behavioural reference model ----------------
    int m_in_base, m_out_base, m_in_size, m_out_size, m_pend, m_full;
    int m_ridx, m_widx, m_infl, m_int, m_err, m_etype, m_eidx, m_halt, m_cfg;

    function automatic bit m_freq();
        return m_pend > 0 && m_halt == 0 && !(m_cfg[2] && m_err) && m_infl < 15;
    endfunction
    function automatic bit m_pready();
        return m_full < m_out_size && m_halt != 2;
    endfunction
    function automatic int m_read(input int a);
        case (a)
            0: return m_in_base;   1: return m_in_size;
            3: return m_in_size - m_pend;  4: return m_ridx;
            5: return m_out_base;  6: return m_out_size;
            8: return m_full;      9: return m_widx;
            10: return (m_eidx << 16) | (m_etype << 8) | (m_halt << 2) | (m_err << 1) | m_int;
            11: return m_cfg;
            default: return 0;
        endcase
    endfunction
    function automatic string tag_of(input int a);
        case (a)
            0, 5, 11: return "R11";  1, 6: return "R2";  3: return "R3";
            4: return "R5";  8: return "R4";  9: return "R6";  10: return "R9";
            default: return "R1";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_in_base = 0; m_out_base = 0; m_in_size = 0; m_out_size = 0; m_pend = 0;
            m_full = 0; m_ridx = 0; m_widx = 0; m_infl = 0; m_int = 0; m_err = 0;
            m_etype = 0; m_eidx = 0; m_halt = 0; m_cfg = 0;
        end else begin
            automatic bit f = fetch_ack && m_freq();
            automatic bit p = post_valid && m_pready();
            automatic bit e_add = 0, e_rm = 0, e_rst = 0;
            automatic int old_halt = m_halt, old_infl = m_infl;
            automatic int old_is = m_in_size, old_os = m_out_size;
            if (wr_en && wr_addr == 2) begin
                if (wr_data > 32'(m_in_size - m_pend)) e_add = 1; else m_pend += int'(wr_data);
            end
            if (wr_en && wr_addr == 7) begin
                if (wr_data > 32'(m_full)) e_rm = 1; else m_full -= int'(wr_data);
            end
            if (f) begin m_pend--; m_ridx = (m_ridx + 1 >= old_is) ? 0 : m_ridx + 1; m_infl++; end
            if (p) begin m_full++; m_widx = (m_widx + 1 >= old_os) ? 0 : m_widx + 1;
                         if (m_infl > 0 && !(f && old_infl == 0)) m_infl--; end
            if (f && p && old_infl == 0) m_infl = 1;
            if (wr_en && wr_addr == 10) begin
                if (wr_data[0]) m_int = 0;
                if (wr_data[1]) begin m_err = 0; m_etype = 0; m_eidx = 0; end
            end
            if (p && !m_cfg[0]) m_int = 1;
            if (wr_en && wr_addr == 12 && wr_data[0] && old_halt != 0) e_rst = 1;
            if (e_add)      begin m_err = 1; m_etype = 9; m_eidx = int'(wr_data[13:0]); end
            else if (e_rm)  begin m_err = 1; m_etype = 8; m_eidx = int'(wr_data[13:0]); end
            else if (e_rst) begin m_err = 1; m_etype = 7; m_eidx = 0; end
            if (old_halt == 0 && wr_en && wr_addr == 12 && wr_data[0]) m_halt = 1;
            if (old_halt == 1 && old_infl == 0) begin
                m_halt = 2; m_pend = 0; m_full = 0; m_ridx = 0; m_widx = 0; m_infl = 0;
            end
            if (old_halt == 2 && wr_en && wr_addr == 10 && wr_data[3]) m_halt = 0;
            if (wr_en) case (wr_addr)
                0: m_in_base = int'(wr_data);   5: m_out_base = int'(wr_data);
                1: m_in_size = int'(wr_data[9:0]); 6: m_out_size = int'(wr_data[9:0]);
                11: m_cfg = int'(wr_data);
                default: ;
            endcase
        end
    end

    task automatic fail1(input string tag, input string what, input int act, input int exp);
        bad++;
        $display("FAIL %s %s actual=0x%08h expected=0x%08h at %0t", tag, what, act, exp, $time);
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        if (rst_n && !done) begin
            #3;
            in_chk = 1'b1;
            for (int a = 0; a < 13; a++) begin
                c_addr = 4'(a);
                #0.5;
                total++;
                if (rd_data !== 32'(m_read(a))) fail1(tag_of(a), "reg", int'(rd_data), m_read(a));
            end
            in_chk = 1'b0;
            total++;
            if (fetch_req !== m_freq()) fail1("R5", "fetch_req", int'(fetch_req), int'(m_freq()));
            total++;
            if (post_ready !== m_pready()) fail1("R6", "post_ready", int'(post_ready), int'(m_pready()));
            total++;
            if (irq !== ((m_int || m_err) && !m_cfg[0])) fail1("R9", "irq", int'(irq), int'((m_int || m_err) && !m_cfg[0]));
            total++;
            if (fetch_idx !== 10'(m_ridx) || post_idx !== 10'(m_widx))
                fail1("R6", "positions", int'({fetch_idx, post_idx}), (m_ridx << 10) | m_widx);
            total++;
            if (in_base !== 32'(m_in_base) || out_base !== 32'(m_out_base))
                fail1("R11", "base ports", int'(in_base), m_in_base);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask
    task automatic ex_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #2; e_addr = a; #0.5;
        total++;
        if (rd_data !== exp) fail1(tag, "directed", int'(rd_data), int'(exp));
    endtask
    task automatic ex_bit(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) fail1(tag, "directed port", int'(act), int'(exp));
    endtask
    task automatic fetch_n(input int n);
        @(negedge clk); fetch_ack = 1'b1; repeat (n) @(negedge clk); fetch_ack = 1'b0;
    endtask
    task automatic post_n(input int n);
        @(negedge clk); post_valid = 1'b1; repeat (n) @(negedge clk); post_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ex_reg(4'd3, 32'h0, "R1"); ex_reg(4'd10, 32'h0, "R1");
        ex_bit(fetch_req, 1'b0, "R1"); ex_bit(irq, 1'b0, "R1");

        wr(4'd0, 32'h1000_0000); wr(4'd5, 32'h2000_0000);
        wr(4'd1, 32'h0000_0404); wr(4'd6, 32'h0000_0003);
        ex_reg(4'd1, 32'd4, "R2"); ex_reg(4'd3, 32'd4, "R3");
        ex_bit(in_base == 32'h1000_0000, 1'b1, "R11");

        wr(4'd2, 32'd3); ex_reg(4'd3, 32'd1, "R3"); ex_bit(fetch_req, 1'b1, "R5");
        wr(4'd2, 32'd2); ex_reg(4'd10, 32'h0002_0902, "R3"); ex_reg(4'd3, 32'd1, "R3");
        wr(4'd10, 32'h2); ex_reg(4'd10, 32'h0, "R9");

        fetch_n(3); ex_reg(4'd4, 32'd3, "R5"); ex_reg(4'd3, 32'd4, "R5");
        wr(4'd2, 32'd2); fetch_n(2); ex_reg(4'd4, 32'd1, "R5");

        post_n(4); ex_reg(4'd8, 32'd3, "R6"); ex_reg(4'd9, 32'd0, "R6");
        ex_bit(post_ready, 1'b0, "R6"); ex_reg(4'd10, 32'h1, "R9"); ex_bit(irq, 1'b1, "R9");
        wr(4'd10, 32'h1); ex_bit(irq, 1'b0, "R9");

        wr(4'd7, 32'd4); ex_reg(4'd10, 32'h0004_0802, "R4"); ex_reg(4'd8, 32'd3, "R4");
        wr(4'd7, 32'd2); ex_reg(4'd8, 32'd1, "R4"); wr(4'd10, 32'h2);

        wr(4'd11, 32'h1); post_n(1); ex_reg(4'd8, 32'd2, "R9");
        ex_reg(4'd10, 32'h0, "R9"); ex_bit(irq, 1'b0, "R9");

        wr(4'd11, 32'h4); wr(4'd2, 32'd5); wr(4'd2, 32'd1);
        ex_bit(fetch_req, 1'b0, "R10");
        wr(4'd10, 32'h2); ex_bit(fetch_req, 1'b1, "R10");

        wr(4'd12, 32'h1); ex_reg(4'd10, 32'h4, "R7"); ex_bit(fetch_req, 1'b0, "R7");
        wr(4'd12, 32'h1); ex_reg(4'd10, 32'h706, "R8");
        post_n(1); repeat (3) @(negedge clk);
        ex_reg(4'd10, 32'h70B, "R7"); ex_reg(4'd8, 32'd0, "R7");
        ex_reg(4'd3, 32'd4, "R7"); ex_reg(4'd4, 32'd0, "R7");
        ex_bit(post_ready, 1'b0, "R7");
        wr(4'd10, 32'hB); ex_reg(4'd10, 32'h0, "R7"); ex_bit(post_ready, 1'b1, "R6");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule